// File: doc/BRIEF.md
# Reset Pulse Controller with Source Flags

This block owns an open-drain, active-low system reset line. It senses the line and can pull it low. Three kinds of event start a reset pulse: an early watchdog fault, a late watchdog fault, and a low-supply indication. A fourth kind is any low level applied to the line from outside, such as a push-button. For every event the block pulls the line low for a fixed number of timebase ticks. A short or bouncing press therefore becomes one clean pulse of full width. While the block is pulling the line it also raises a lockout output, so the host bus interface ignores commands for that time.

The block keeps a sticky flag for each hardware reset source in a status byte. Software reads that byte and clears the flags by writing ones to it. A reset that leaves every flag clear was caused from outside, for example by the push-button. The line level the block drives makes the line read low, and that low is masked so that the block does not trigger itself. A line that is still held low from outside after the pulse ends does not start another pulse and does not extend the lockout.

Top module: `rst_pulse_ctrl`

## Requirements
- R1: After reset, pin_drive_low and bus_lockout are 0 and flags_out reads 8'h00.
- R2: A lowv_req high at a clock edge drives pin_drive_low high from the next cycle for exactly PULSE_TICKS*TICK_DIV cycles and sets flags_out bit 5.
- R3: A wdt_early_req produces the same pulse and sets flags_out bit 7. A wdt_late_req produces the same pulse and sets flags_out bit 6.
- R4: A low on pin_in starts the same full-width pulse. pin_drive_low rises two cycles after the first edge at which pin_in is sampled low, because of a two-stage synchronizer. No flag is set.
- R5: A pin_in low lasting one clock cycle still yields a pulse of the full PULSE_TICKS*TICK_DIV cycles.
- R6: Any hardware request that arrives during a pulse restarts the full width from the cycle after it. Flags that are already set stay set.
- R7: pin_in is ignored while pin_drive_low is high and for TICK_DIV cycles after it falls. An external low that continues after a pulse starts no new pulse until pin_in has been seen high again.
- R8: bus_lockout is high in exactly the cycles in which pin_drive_low is high. A continued external hold does not extend it.
- R9: A write with reg_wr_en high to reg_addr == STATUS_ADDR (default 8'h09) clears each flag whose bit in reg_wdata is 1 (bits 7, 6, 5) and leaves the others. Writes to any other address change nothing.
- R10: When a flag's set event and its clear write happen in the same cycle, the flag ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wdt_early_req | input | 1 | Early watchdog fault request |
| wdt_late_req | input | 1 | Late watchdog fault request |
| lowv_req | input | 1 | Low-supply request |
| pin_in | input | 1 | Sensed level of the reset line |
| pin_drive_low | output | 1 | Open-drain pull-down enable |
| bus_lockout | output | 1 | High while the block is driving the line |
| reg_wr_en | input | 1 | Status register write strobe |
| reg_addr | input | ADDR_W | Write address |
| reg_wdata | input | 8 | Write data (a 1 clears the matching flag) |
| flags_out | output | 8 | Status byte: bit 7 early fault, bit 6 late fault, bit 5 low supply |

## Verification
The bench measures the width of each pulse cycle by cycle. A timer that is off by one tick, or that does not reload when a second request arrives mid-pulse, shows up as a wrong count. It releases the line and then pulls it low again inside the masking window, and it also holds the line low for longer than a pulse. A design without the post-release mask retriggers on its own echo, and a design without re-arming repeats pulses forever while the line is held. It writes to a wrong address, writes zero bits, and lets a set and a clear collide in one cycle. A design that decodes too loosely loses flags, and one that gives the clear priority drops a reset cause.

// File: rtl/rpc_pkg.sv
// Package: shared constants and types for the reset pulse controller.
// Assumes an 8-bit status register whose top three bits hold the flags.
package rpc_pkg;

    localparam int REG_W    = 8;
    localparam int N_FLAGS  = 3;
    // Flag index i lives at status bit FLAG_LSB + i.
    localparam int FLAG_LSB = 5;
    localparam int IDX_LOWV = 0;   // bit 5
    localparam int IDX_LATE = 1;   // bit 6
    localparam int IDX_EARLY = 2;  // bit 7

    // Hardware reset sources captured in one cycle.
    typedef struct packed {
        logic early_wd;
        logic late_wd;
        logic lowv;
    } rpc_src_t;

endpackage

// File: rtl/rpc_tick_gen.sv
// Module: timebase prescaler. Emits a one-cycle tick every TICK_DIV clocks.
// Assumes: restart re-aligns the phase so that a pulse starting now sees its
// first tick exactly TICK_DIV cycles later.
module rpc_tick_gen #(
    parameter int TICK_DIV = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    output logic tick
);
    localparam int CW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(TICK_DIV - 1);

    logic [CW-1:0] div_q;

    // Count clocks modulo TICK_DIV, restarting from zero on request.
    always_ff @(posedge clk) begin
        if (!rst_n || restart) begin
            div_q <= '0;
        end else if (div_q == LAST) begin
            div_q <= '0;
        end else begin
            div_q <= div_q + 1'b1;
        end
    end

    // Tick on the last count of each period.
    always_comb tick = (div_q == LAST);

endmodule

// File: rtl/rpc_pin_sense.sv
// Module: reset line sense. Synchronizes the sensed level, masks it while the
// block itself is pulling low, and issues one request per external low.
// Assumes: blank covers the drive interval plus the settling time after it.
module rpc_pin_sense (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_in,
    input  logic blank,
    output logic manual_req
);
    logic sync1_q, sync2_q;
    logic armed_q;

    // Two-stage synchronizer, idle high.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync1_q <= 1'b1;
            sync2_q <= 1'b1;
        end else begin
            sync1_q <= pin_in;
            sync2_q <= sync1_q;
        end
    end

    // Arm once the line is seen high while unmasked; disarm on a request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            armed_q <= 1'b0;
        end else if (manual_req) begin
            armed_q <= 1'b0;
        end else if (sync2_q && !blank) begin
            armed_q <= 1'b1;
        end
    end

    // Request when an armed, unmasked line reads low.
    always_comb manual_req = armed_q && !sync2_q && !blank;

endmodule

// File: rtl/rpc_pulse_timer.sv
// Module: pulse timer. Holds active for PULSE_TICKS ticks after each start
// (a start during a pulse reloads it), then raises holdoff for one tick.
// Assumes: tick phase is restarted together with start.
module rpc_pulse_timer #(
    parameter int PULSE_TICKS = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic tick,
    output logic active,
    output logic holdoff
);
    localparam int RW = $clog2(PULSE_TICKS + 1);
    localparam logic [RW-1:0] FULL = RW'(PULSE_TICKS);
    localparam logic [RW-1:0] ONE  = RW'(1);

    logic [RW-1:0] remain_q;
    logic          active_q;
    logic          holdoff_q;
    logic          last_tick;

    // Final tick of the running pulse.
    always_comb last_tick = active_q && tick && (remain_q == ONE);

    // Load on start, count down on ticks, drop at zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active_q <= 1'b0;
            remain_q <= '0;
        end else if (start) begin
            active_q <= 1'b1;
            remain_q <= FULL;
        end else if (active_q && tick) begin
            remain_q <= remain_q - 1'b1;
            if (remain_q == ONE) begin
                active_q <= 1'b0;
            end
        end
    end

    // Mask the line for one tick after release.
    always_ff @(posedge clk) begin
        if (!rst_n || start) begin
            holdoff_q <= 1'b0;
        end else if (last_tick) begin
            holdoff_q <= 1'b1;
        end else if (holdoff_q && tick) begin
            holdoff_q <= 1'b0;
        end
    end

    assign active  = active_q;
    assign holdoff = holdoff_q;

endmodule

// File: rtl/rpc_flag_reg.sv
// Module: sticky source flags with write-one-to-clear at STATUS_ADDR.
// Assumes: a set event in the same cycle as a clear takes priority.
module rpc_flag_reg
    import rpc_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter logic [ADDR_W-1:0] STATUS_ADDR = 8'h09
) (
    input  logic              clk,
    input  logic              rst_n,
    input  rpc_src_t          set_src,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [REG_W-1:0]  wr_data,
    output logic [REG_W-1:0]  status
);
    logic [N_FLAGS-1:0] set_vec;
    logic [N_FLAGS-1:0] clr_vec;
    logic [N_FLAGS-1:0] flag_q;
    logic               hit;
    logic               unused_low_bits;

    // Address decode of the status register.
    always_comb hit = wr_en && (wr_addr == STATUS_ADDR);

    // Map sources to flag indices.
    always_comb begin
        set_vec            = '0;
        set_vec[IDX_LOWV]  = set_src.lowv;
        set_vec[IDX_LATE]  = set_src.late_wd;
        set_vec[IDX_EARLY] = set_src.early_wd;
    end

    // Clear mask from the written ones.
    always_comb clr_vec = hit ? wr_data[FLAG_LSB +: N_FLAGS] : '0;

    assign unused_low_bits = ^wr_data[FLAG_LSB-1:0];

    for (genvar i = 0; i < N_FLAGS; i++) begin : g_flag
        // One sticky bit: set wins over clear.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                flag_q[i] <= 1'b0;
            end else if (set_vec[i]) begin
                flag_q[i] <= 1'b1;
            end else if (clr_vec[i]) begin
                flag_q[i] <= 1'b0;
            end
        end
    end

    // Place flags in the status byte.
    always_comb begin
        status = '0;
        status[FLAG_LSB +: N_FLAGS] = flag_q;
    end

endmodule

// File: rtl/rst_pulse_ctrl.sv
// Module: reset pulse controller top. Merges hardware and line-sensed
// requests, drives the open-drain line for a fixed width, raises the bus
// lockout while driving and records the hardware source in sticky flags.
// Assumes: an external pull-up on the line; pin_in reads the line level.
module rst_pulse_ctrl
    import rpc_pkg::*;
#(
    parameter int PULSE_TICKS = 100,
    parameter int TICK_DIV    = 50000,
    parameter int ADDR_W      = 8,
    parameter logic [ADDR_W-1:0] STATUS_ADDR = 8'h09
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wdt_early_req,
    input  logic              wdt_late_req,
    input  logic              lowv_req,
    input  logic              pin_in,
    output logic              pin_drive_low,
    output logic              bus_lockout,
    input  logic              reg_wr_en,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [REG_W-1:0]  reg_wdata,
    output logic [REG_W-1:0]  flags_out
);
    rpc_src_t hw_src;
    logic     manual_req;
    logic     start;
    logic     tick;
    logic     active;
    logic     holdoff;
    logic     blank;

    // Gather hardware sources.
    always_comb begin
        hw_src.early_wd = wdt_early_req;
        hw_src.late_wd  = wdt_late_req;
        hw_src.lowv     = lowv_req;
    end

    // Any source (re)starts a pulse; the line is masked during and after it.
    always_comb start = wdt_early_req || wdt_late_req || lowv_req || manual_req;
    always_comb blank = active || holdoff;

    rpc_tick_gen #(.TICK_DIV(TICK_DIV)) u_tick (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (start),
        .tick    (tick)
    );

    rpc_pin_sense u_sense (
        .clk        (clk),
        .rst_n      (rst_n),
        .pin_in     (pin_in),
        .blank      (blank),
        .manual_req (manual_req)
    );

    rpc_pulse_timer #(.PULSE_TICKS(PULSE_TICKS)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (start),
        .tick    (tick),
        .active  (active),
        .holdoff (holdoff)
    );

    rpc_flag_reg #(.ADDR_W(ADDR_W), .STATUS_ADDR(STATUS_ADDR)) u_flags (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_src (hw_src),
        .wr_en   (reg_wr_en),
        .wr_addr (reg_addr),
        .wr_data (reg_wdata),
        .status  (flags_out)
    );

    assign pin_drive_low = active;
    assign bus_lockout   = active;

endmodule

// File: rtl/rpc_checker.sv
// Module: property checker for rst_pulse_ctrl, attached by bind below.
module rpc_checker #(
    parameter int ADDR_W = 8,
    parameter logic [ADDR_W-1:0] STATUS_ADDR = 8'h09
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wdt_early_req,
    input logic              wdt_late_req,
    input logic              lowv_req,
    input logic              pin_in,
    input logic              pin_drive_low,
    input logic              reg_wr_en,
    input logic [ADDR_W-1:0] reg_addr,
    input logic [2:0]        wdata_hi,
    input logic [2:0]        flags_hi
);
    logic clr_hit;
    assign clr_hit = reg_wr_en && (reg_addr == STATUS_ADDR);

    // R2
    lowv_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lowv_req |=> flags_hi[0]);

    // R3
    early_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wdt_early_req |=> flags_hi[2]);

    // R3
    late_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wdt_late_req |=> flags_hi[1]);

    // R6
    req_drives_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wdt_early_req || wdt_late_req || lowv_req) |=> pin_drive_low);

    // R9
    early_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flags_hi[2] && !(clr_hit && wdata_hi[2])) |=> flags_hi[2]);

    // R9
    late_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flags_hi[1] && !(clr_hit && wdata_hi[1])) |=> flags_hi[1]);

    // R9
    lowv_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flags_hi[0] && !(clr_hit && wdata_hi[0])) |=> flags_hi[0]);

    // R4
    drive_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pin_drive_low) |->
            ($past(wdt_early_req || wdt_late_req || lowv_req) || $past(!pin_in, 3)));

endmodule

bind rst_pulse_ctrl rpc_checker #(.ADDR_W(ADDR_W), .STATUS_ADDR(STATUS_ADDR)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .wdt_early_req (wdt_early_req),
    .wdt_late_req  (wdt_late_req),
    .lowv_req      (lowv_req),
    .pin_in        (pin_in),
    .pin_drive_low (pin_drive_low),
    .reg_wr_en     (reg_wr_en),
    .reg_addr      (reg_addr),
    .wdata_hi      (reg_wdata[7:5]),
    .flags_hi      (flags_out[7:5])
);

// File: tb/rst_pulse_ctrl_tb.sv
// Directed bench for rst_pulse_ctrl: one task per scenario.
module rst_pulse_ctrl_tb;
    localparam int P = 8;
    localparam int D = 4;
    localparam int W = P * D;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       early = 1'b0, late = 1'b0, lowv = 1'b0, ext_low = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] addr = 8'h00, wdata = 8'h00;
    logic       drive, lockout, pin_in;
    logic [7:0] flags;
    int         nvec = 0, nfail = 0;
    bit         done = 1'b0;

    always #10 clk = ~clk;
    assign pin_in = ~(drive | ext_low);

    rst_pulse_ctrl #(.PULSE_TICKS(P), .TICK_DIV(D), .ADDR_W(8), .STATUS_ADDR(8'h09)) u_dut (
        .clk(clk), .rst_n(rst_n), .wdt_early_req(early), .wdt_late_req(late),
        .lowv_req(lowv), .pin_in(pin_in), .pin_drive_low(drive), .bus_lockout(lockout),
        .reg_wr_en(wr_en), .reg_addr(addr), .reg_wdata(wdata), .flags_out(flags)
    );

    task automatic check(input string req, input int act, input int exp);
        nvec++;
        if (act != exp) begin
            nfail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Count consecutive high-drive negedges from now; flag lockout mismatches.
    task automatic count_high(output int n, output int mism);
        n = 0; mism = 0;
        while (drive && n < 1000) begin
            if (lockout !== drive) mism++;
            n++;
            @(negedge clk);
        end
        if (lockout !== drive) mism++;
    endtask

    task automatic reg_write(input logic [7:0] a, input logic [7:0] d);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic clear_all();
        reg_write(8'h09, 8'hE0);
        repeat (D + 2) @(negedge clk);
    endtask

    task automatic t_reset();
        check("R1 drive", int'(drive), 0);
        check("R1 lockout", int'(lockout), 0);
        check("R1 flags", int'(flags), 8'h00);
    endtask

    task automatic t_hw(input int which, input int exp_flags, input string req);
        int n, m;
        if (which == 0) lowv = 1'b1; else if (which == 1) early = 1'b1; else late = 1'b1;
        @(negedge clk);
        lowv = 1'b0; early = 1'b0; late = 1'b0;
        count_high(n, m);
        check({req, " width"}, n, W);
        check("R8 lockout tracks drive", m, 0);
        check({req, " flags"}, int'(flags), exp_flags);
        clear_all();
    endtask

    task automatic t_manual_short();
        int n, m;
        ext_low = 1'b1;
        @(negedge clk);
        ext_low = 1'b0;
        @(negedge clk);
        check("R4 latency not early", int'(drive), 0);
        @(negedge clk);
        check("R4 drive after sync", int'(drive), 1);
        count_high(n, m);
        check("R5 short press full width", n, W);
        check("R4 no flag", int'(flags), 8'h00);
        repeat (D + 4) @(negedge clk);
    endtask

    task automatic t_retrigger();
        int n, m;
        lowv = 1'b1;
        @(negedge clk);
        lowv = 1'b0;
        repeat (9) @(negedge clk);
        early = 1'b1;
        @(negedge clk);
        early = 1'b0;
        count_high(n, m);
        check("R6 restart width", n, W);
        check("R6 flags kept", int'(flags), 8'hA0);
        clear_all();
    endtask

    task automatic t_hold();
        int n, m, extra;
        ext_low = 1'b1;
        repeat (3) @(negedge clk);
        count_high(n, m);
        check("R8 held pulse width", n, W);
        check("R8 lockout tracks drive", m, 0);
        extra = 0;
        for (int i = 0; i < 40; i++) begin
            if (drive || lockout) extra++;
            @(negedge clk);
        end
        check("R7 hold no retrigger", extra, 0);
        ext_low = 1'b0;
        repeat (6) @(negedge clk);
        ext_low = 1'b1;
        @(negedge clk);
        ext_low = 1'b0;
        repeat (2) @(negedge clk);
        count_high(n, m);
        check("R7 rearmed after high", n, W);
        repeat (D + 4) @(negedge clk);
    endtask

    task automatic t_holdoff();
        int n, m, extra;
        lowv = 1'b1;
        @(negedge clk);
        lowv = 1'b0;
        count_high(n, m);
        ext_low = 1'b1;
        @(negedge clk);
        ext_low = 1'b0;
        extra = 0;
        for (int i = 0; i < 20; i++) begin
            if (drive) extra++;
            @(negedge clk);
        end
        check("R7 holdoff masks line", extra, 0);
        clear_all();
    endtask

    task automatic t_w1c();
        int n, m;
        early = 1'b1; late = 1'b1; lowv = 1'b1;
        @(negedge clk);
        early = 1'b0; late = 1'b0; lowv = 1'b0;
        count_high(n, m);
        check("R9 all set", int'(flags), 8'hE0);
        reg_write(8'h0A, 8'hFF);
        check("R9 other addr ignored", int'(flags), 8'hE0);
        reg_write(8'h09, 8'h80);
        check("R9 clear bit7 only", int'(flags), 8'h60);
        reg_write(8'h09, 8'h1F);
        check("R9 zero bits keep", int'(flags), 8'h60);
        reg_write(8'h09, 8'h60);
        check("R9 clear rest", int'(flags), 8'h00);
        repeat (D + 2) @(negedge clk);
    endtask

    task automatic t_set_wins();
        int n, m;
        lowv = 1'b1; wr_en = 1'b1; addr = 8'h09; wdata = 8'h20;
        @(negedge clk);
        lowv = 1'b0; wr_en = 1'b0;
        check("R10 set beats clear", int'(flags), 8'h20);
        count_high(n, m);
        clear_all();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        repeat (4) @(negedge clk);
        t_hw(0, 8'h20, "R2 lowv");
        t_hw(1, 8'h80, "R3 early");
        t_hw(2, 8'h40, "R3 late");
        t_manual_short();
        t_retrigger();
        t_hold();
        t_holdoff();
        t_w1c();
        t_set_wins();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            nvec++; nfail++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
            $finish;
        end
    end
endmodule